// File: doc/BRIEF.md
# ATM Transmit Cell Source Arbiter

This block produces the transmit-side stream of 53-byte ATM cells, one byte per clock and with no gaps. At every cell boundary it picks one of three sources. The first is a cell that software has loaded into a local OAM buffer and asked to be sent. The second is a user cell read from the transmit FIFO, which is taken only when that FIFO reports a complete cell. The third is an idle cell, built from five programmable header registers and one payload byte that fills the whole payload. Once a cell has started it always runs to its last byte.

User and OAM cells have their fifth header byte replaced by a computed HEC. Idle cells are sent exactly as they are programmed. A single-cycle valid-cell strobe marks the last byte of every user or OAM cell, so a counter outside the block can tally the cells that carry traffic.

Software reaches the OAM buffer, the send-request bit and the idle-pattern registers through a byte-wide register port. The send-request bit clears itself when the OAM cell has gone out, so software can poll it to see whether the send has completed.

Top module: `atm_tx_cell_src`

## Requirements
- R1: While reset is held, and straight after it, `cell_data_o`, `cell_soc_o` and `valid_cell_o` are 0. The control register at 0x40 reads 00h. The idle header registers at 0x48..0x4C read 00h, 00h, 00h, 01h and 52h, and the idle payload register at 0x4D reads 6Ah.
- R2: Output bytes follow one another on every clock. `cell_soc_o` is high on the first byte of each cell, and consecutive start flags are exactly 53 cycles apart.
- R3: The source of a cell is chosen in the cycle that produces its first byte. A pending OAM request wins over a complete user cell, and a complete user cell wins over an idle cell. `fifo_rd_o` is high for all 53 cycles of a user cell and low for every other cell, so each user cell pops exactly 53 bytes.
- R4: A user cell carries the 53 popped FIFO bytes in the order they were popped, except that byte 5 is the HEC.
- R5: The HEC is a CRC-8 with generator x^8+x^2+x+1, initial value 0, computed most significant bit first over header bytes 1 to 4 of the cell, then XORed with 55h.
- R6: Writing a byte with bit 7 set to 0x40 makes a request pending. The next cell is then the 53-byte OAM buffer, held at addresses 0x00..0x34 in cell order, with byte 5 replaced by the HEC. Bit 7 of 0x40 reads 1 while the request is pending and 0 from the cycle in which the last OAM byte appears. Writing 0 to bit 7 has no effect.
- R7: An idle cell sends header bytes 1 to 5 from 0x48..0x4C without any HEC substitution, then 48 copies of the payload register at 0x4D.
- R8: `valid_cell_o` is high for exactly one cycle, together with byte 53 of each user or OAM cell, and it is never high during an idle cell.
- R9: The idle registers and the OAM buffer read back the values last written to them. Bits 6:0 of 0x40 always read 0, whatever was written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational from the address |
| fifo_cell_avail_i | input | 1 | The FIFO holds at least one complete cell |
| fifo_data_i | input | 8 | FIFO head byte (show-ahead) |
| fifo_rd_o | output | 1 | Pop the FIFO head byte at this clock edge |
| cell_data_o | output | 8 | Outgoing cell byte |
| cell_soc_o | output | 1 | First byte of a cell |
| valid_cell_o | output | 1 | Last byte of a user or OAM cell |

## Verification
The source decision and every cell byte are formed in one cycle and registered, so each byte, its start flag and the valid strobe appear one clock after the cycle whose inputs chose them. The bench therefore records the pending-request state, the FIFO-available flag and the FIFO read pointer at every falling edge. When it sees a start flag it builds the expected cell from the record of the previous falling edge. A write to the control register is visible in its read data at the next falling edge. The bit clears at the falling edge that shows the last OAM byte, and the bench compares the read data with its own model at every falling edge.

// File: rtl/atm_tx_pkg.sv
package atm_tx_pkg;

  typedef enum logic [1:0] {
    SRC_IDLE = 2'd0,
    SRC_USER = 2'd1,
    SRC_OAM  = 2'd2
  } src_e;

  localparam logic [7:0] HEC_POLY  = 8'h07;
  localparam logic [7:0] HEC_COSET = 8'h55;

  // one byte of CRC-8, msb first
  function automatic logic [7:0] crc8_step(input logic [7:0] crc, input logic [7:0] d);
    logic [7:0] c;
    c = crc ^ d;
    for (int i = 0; i < 8; i++) c = c[7] ? ((c << 1) ^ HEC_POLY) : (c << 1);
    return c;
  endfunction

endpackage

// File: rtl/atm_tx_regs.sv
module atm_tx_regs import atm_tx_pkg::*; #(
  parameter int unsigned        CELL_BYTES   = 53,
  parameter int unsigned        HDR_BYTES    = 5,
  parameter int unsigned        ADDR_W       = 8,
  parameter logic [ADDR_W-1:0]  CTRL_ADDR    = 8'h40,
  parameter logic [ADDR_W-1:0]  IDLE_BASE    = 8'h48,
  parameter logic [8*HDR_BYTES-1:0] IDLE_HDR_DEF = 40'h00_00_00_01_52,
  parameter logic [7:0]         IDLE_PAY_DEF = 8'h6A,
  localparam int unsigned       CNT_W        = $clog2(CELL_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic [CNT_W-1:0]  oam_idx_i,
  output logic [7:0]        oam_byte_o,
  input  logic              oam_done_i,
  output logic              oam_pend_o,
  output logic [7:0]        idle_hdr_o [HDR_BYTES],
  output logic [7:0]        idle_pay_o
);

  localparam logic [ADDR_W-1:0] PAY_ADDR = IDLE_BASE + ADDR_W'(HDR_BYTES);

  logic [7:0] oam_mem [CELL_BYTES];
  logic [7:0] idle_hdr_q [HDR_BYTES];
  logic [7:0] idle_pay_q;
  logic       pend_q;
  logic       oam_hit;

  assign oam_hit = addr_i < ADDR_W'(CELL_BYTES);

  always_ff @(posedge clk_i) begin
    if (we_i && oam_hit) oam_mem[addr_i[CNT_W-1:0]] <= wdata_i;
  end

  for (genvar g = 0; g < HDR_BYTES; g++) begin : g_hdr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        idle_hdr_q[g] <= IDLE_HDR_DEF[8*(HDR_BYTES-1-g) +: 8];
      else if (we_i && addr_i == IDLE_BASE + ADDR_W'(g))
        idle_hdr_q[g] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_pay_q <= IDLE_PAY_DEF;
      pend_q     <= 1'b0;
    end else begin
      if (we_i && addr_i == PAY_ADDR) idle_pay_q <= wdata_i;
      // a new request wins over completion of the previous one
      if (we_i && addr_i == CTRL_ADDR && wdata_i[7]) pend_q <= 1'b1;
      else if (oam_done_i)                           pend_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (oam_hit)                     rdata_o = oam_mem[addr_i[CNT_W-1:0]];
    else if (addr_i == CTRL_ADDR)    rdata_o = {pend_q, 7'b0};
    else if (addr_i == PAY_ADDR)     rdata_o = idle_pay_q;
    for (int i = 0; i < HDR_BYTES; i++)
      if (addr_i == IDLE_BASE + ADDR_W'(i)) rdata_o = idle_hdr_q[i];
  end

  assign oam_byte_o = oam_mem[oam_idx_i];
  assign oam_pend_o = pend_q;
  assign idle_hdr_o = idle_hdr_q;
  assign idle_pay_o = idle_pay_q;

endmodule

// File: rtl/atm_tx_seq.sv
module atm_tx_seq import atm_tx_pkg::*; #(
  parameter int unsigned  CELL_BYTES = 53,
  localparam int unsigned CNT_W      = $clog2(CELL_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             oam_pend_i,
  input  logic             fifo_cell_avail_i,
  output logic [CNT_W-1:0] cnt_o,
  output src_e             src_o,
  output logic             first_o,
  output logic             last_o
);

  logic [CNT_W-1:0] cnt_q;
  src_e             src_q, pick;

  always_comb begin
    if (oam_pend_i)             pick = SRC_OAM;
    else if (fifo_cell_avail_i) pick = SRC_USER;
    else                        pick = SRC_IDLE;
  end

  assign first_o = cnt_q == '0;
  assign last_o  = cnt_q == CNT_W'(CELL_BYTES-1);
  assign src_o   = first_o ? pick : src_q;
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      src_q <= SRC_IDLE;
    end else begin
      cnt_q <= last_o ? '0 : cnt_q + 1'b1;
      if (first_o) src_q <= pick;
    end
  end

endmodule

// File: rtl/atm_tx_hec.sv
module atm_tx_hec import atm_tx_pkg::*; #(
  parameter int unsigned HDR_BYTES = 5,
  parameter int unsigned CNT_W     = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [7:0]       byte_i,
  output logic [7:0]       hec_o
);

  logic [7:0] crc_q, base;

  assign base = (cnt_i == '0) ? 8'h00 : crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              crc_q <= 8'h00;
    else if (cnt_i < CNT_W'(HDR_BYTES-1))     crc_q <= crc8_step(base, byte_i);
  end

  // valid while the counter sits on the last header byte
  assign hec_o = crc_q ^ HEC_COSET;

endmodule

// File: rtl/atm_tx_cell_src.sv
module atm_tx_cell_src import atm_tx_pkg::*; #(
  parameter int unsigned            CELL_BYTES   = 53,
  parameter int unsigned            HDR_BYTES    = 5,
  parameter int unsigned            ADDR_W       = 8,
  parameter logic [ADDR_W-1:0]      CTRL_ADDR    = 8'h40,
  parameter logic [ADDR_W-1:0]      IDLE_BASE    = 8'h48,
  parameter logic [8*HDR_BYTES-1:0] IDLE_HDR_DEF = 40'h00_00_00_01_52,
  parameter logic [7:0]             IDLE_PAY_DEF = 8'h6A
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  input  logic              fifo_cell_avail_i,
  input  logic [7:0]        fifo_data_i,
  output logic              fifo_rd_o,
  output logic [7:0]        cell_data_o,
  output logic              cell_soc_o,
  output logic              valid_cell_o
);

  localparam int unsigned CNT_W  = $clog2(CELL_BYTES);
  localparam int unsigned HSEL_W = $clog2(HDR_BYTES);

  logic [CNT_W-1:0] cnt;
  src_e             src;
  logic             first, last, oam_pend, oam_done;
  logic [7:0]       oam_byte, idle_pay, hec, raw_byte, next_byte;
  logic [7:0]       idle_hdr [HDR_BYTES];

  atm_tx_regs #(
    .CELL_BYTES(CELL_BYTES), .HDR_BYTES(HDR_BYTES), .ADDR_W(ADDR_W),
    .CTRL_ADDR(CTRL_ADDR), .IDLE_BASE(IDLE_BASE),
    .IDLE_HDR_DEF(IDLE_HDR_DEF), .IDLE_PAY_DEF(IDLE_PAY_DEF)
  ) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .oam_idx_i(cnt), .oam_byte_o(oam_byte), .oam_done_i(oam_done), .oam_pend_o(oam_pend),
    .idle_hdr_o(idle_hdr), .idle_pay_o(idle_pay)
  );

  atm_tx_seq #(.CELL_BYTES(CELL_BYTES)) u_seq (
    .clk_i, .rst_ni,
    .oam_pend_i(oam_pend), .fifo_cell_avail_i(fifo_cell_avail_i),
    .cnt_o(cnt), .src_o(src), .first_o(first), .last_o(last)
  );

  atm_tx_hec #(.HDR_BYTES(HDR_BYTES), .CNT_W(CNT_W)) u_hec (
    .clk_i, .rst_ni, .cnt_i(cnt), .byte_i(raw_byte), .hec_o(hec)
  );

  always_comb begin
    case (src)
      SRC_USER: raw_byte = fifo_data_i;
      SRC_OAM:  raw_byte = oam_byte;
      default:  raw_byte = (cnt < CNT_W'(HDR_BYTES)) ? idle_hdr[cnt[HSEL_W-1:0]] : idle_pay;
    endcase
    next_byte = (src != SRC_IDLE && cnt == CNT_W'(HDR_BYTES-1)) ? hec : raw_byte;
  end

  assign fifo_rd_o = src == SRC_USER;
  assign oam_done  = last && src == SRC_OAM;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cell_data_o  <= '0;
      cell_soc_o   <= 1'b0;
      valid_cell_o <= 1'b0;
    end else begin
      cell_data_o  <= next_byte;
      cell_soc_o   <= first;
      valid_cell_o <= last && src != SRC_IDLE;
    end
  end

endmodule

// File: rtl/atm_tx_chk.sv
module atm_tx_chk #(
  parameter int unsigned CELL_BYTES = 53
) (
  input logic clk_i,
  input logic rst_ni,
  input logic cell_soc_o,
  input logic valid_cell_o,
  input logic fifo_rd_o,
  input logic fifo_cell_avail_i,
  input logic oam_pend_i
);

  logic [15:0] gap_q;
  logic        seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (cell_soc_o) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else if (gap_q != '1) begin
      gap_q  <= gap_q + 1'b1;
    end
  end

  AST_SOC_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cell_soc_o && seen_q) |-> (gap_q == 16'(CELL_BYTES-1))); // R2

  AST_RD_NEEDS_CELL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fifo_rd_o) |-> (fifo_cell_avail_i && !oam_pend_i)); // R3

  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_cell_o |=> !valid_cell_o); // R8

  AST_VALID_ENDS_CELL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_cell_o |=> cell_soc_o); // R8

  AST_OAM_CLEAR_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(oam_pend_i) |-> valid_cell_o); // R6

endmodule

bind atm_tx_cell_src atm_tx_chk #(.CELL_BYTES(CELL_BYTES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cell_soc_o(cell_soc_o), .valid_cell_o(valid_cell_o),
  .fifo_rd_o(fifo_rd_o), .fifo_cell_avail_i(fifo_cell_avail_i), .oam_pend_i(oam_pend)
);

// File: tb/tb_atm_tx_cell_src.sv
module tb_atm_tx_cell_src;

  localparam logic [7:0] CTRL = 8'h40;
  localparam logic [7:0] IDLE = 8'h48;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       reg_we_i = 1'b0;
  logic [7:0] reg_addr_i = '0, reg_wdata_i = '0, reg_rdata_o;
  logic       fifo_cell_avail_i, fifo_rd_o;
  logic [7:0] fifo_data_i, cell_data_o;
  logic       cell_soc_o, valid_cell_o;

  atm_tx_cell_src dut (.*);

  always #10 clk_i = ~clk_i;

  // bench FIFO: ring of random bytes, show-ahead head
  logic [7:0] fifo_mem [1024];
  int         rd_ptr = 0, wr_ptr = 0;
  logic       gate = 1'b0;
  assign fifo_data_i       = fifo_mem[rd_ptr % 1024];
  assign fifo_cell_avail_i = gate && (wr_ptr - rd_ptr >= 53);

  always @(posedge clk_i) begin
    if (fifo_rd_o) rd_ptr <= rd_ptr + 1;
    if (wr_ptr - rd_ptr < 400) begin
      fifo_mem[wr_ptr % 1024] <= 8'($urandom);
      wr_ptr <= wr_ptr + 1;
    end
  end

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] hec_of(input logic [7:0] b0, b1, b2, b3);
    logic [7:0] c = 8'h00;
    logic [7:0] h [4];
    h[0] = b0; h[1] = b1; h[2] = b2; h[3] = b3;
    for (int k = 0; k < 4; k++)
      for (int i = 7; i >= 0; i--) begin
        logic fb = c[7] ^ h[k][i];
        c = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
      end
    return c ^ 8'h55;
  endfunction

  // models
  logic [7:0] oam_m [53];
  logic [7:0] hdr_m [5];
  logic [7:0] pay_m;

  // monitor state
  logic [7:0] exp_c [53];
  int  bidx = 0, csrc = 0, cstart = 0;
  bit  in_cell = 0, armed = 0;
  bit  req_flag = 0, pend_model = 0, pend_set_next = 0;
  bit  snap_req = 0, snap_avail = 0;
  int  snap_rd = 0;
  string tag;

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [7:0] e, input string req);
    @(negedge clk_i);
    reg_addr_i = a;
    #2;
    chk(reg_rdata_o == e, req, reg_rdata_o, e);
  endtask

  task automatic mon();
    if (pend_set_next) begin pend_model = 1; pend_set_next = 0; end
    if (cell_soc_o && armed) begin
      if (in_cell) chk(bidx == 52, "R2 start spacing", bidx, 52);
      in_cell = 1; bidx = 0; cstart = snap_rd;
      csrc = snap_req ? 2 : (snap_avail ? 1 : 0);
      if (csrc == 2) req_flag = 0;
      for (int i = 0; i < 53; i++) begin
        if (csrc == 1)      exp_c[i] = fifo_mem[(cstart + i) % 1024];
        else if (csrc == 2) exp_c[i] = oam_m[i];
        else                exp_c[i] = (i < 5) ? hdr_m[i] : pay_m;
      end
      if (csrc != 0) exp_c[4] = hec_of(exp_c[0], exp_c[1], exp_c[2], exp_c[3]);
    end else if (in_cell) begin
      bidx++;
    end
    if (in_cell) begin
      if (bidx > 52) begin
        chk(0, "R2 missing start", bidx, 52);
        in_cell = 0;
      end else begin
        tag = (csrc == 1) ? "R4 user byte" : (csrc == 2) ? "R6 oam byte" : "R7 idle byte";
        if (bidx == 4 && csrc != 0) tag = "R5 hec byte";
        chk(cell_data_o == exp_c[bidx], tag, cell_data_o, exp_c[bidx]);
        chk(valid_cell_o == (bidx == 52 && csrc != 0), "R8 valid strobe", valid_cell_o,
            (bidx == 52 && csrc != 0));
        if (bidx == 52) begin
          chk(rd_ptr == cstart + (csrc == 1 ? 53 : 0), "R3 pops per cell", rd_ptr - cstart,
              csrc == 1 ? 53 : 0);
          if (csrc == 2) pend_model = 0;
        end
      end
    end
    if (armed && !reg_we_i)
      chk(reg_rdata_o == {pend_model, 7'b0}, "R6 control readback", reg_rdata_o,
          {pend_model, 7'b0});
  endtask

  task automatic run(input int n, input int gate_mode, input int rq_mode);
    for (int c = 0; c < n; c++) begin
      @(negedge clk_i);
      mon();
      reg_we_i = 1'b0;
      reg_addr_i = CTRL;
      snap_req = req_flag;
      if (gate_mode == 0)      gate = 1'b0;
      else if (gate_mode == 1) gate = 1'b1;
      else                     gate = ($urandom % 4) != 0;
      if (rq_mode != 0 && !req_flag && !pend_model &&
          (rq_mode == 2 || ($urandom % 40) == 0)) begin
        reg_we_i = 1'b1; reg_wdata_i = 8'h80 | 8'($urandom % 128);
        req_flag = 1; pend_set_next = 1;
      end else if (rq_mode != 0 && ($urandom % 16) == 0) begin
        // bit 7 clear: no request (R6)
        reg_we_i = 1'b1; reg_wdata_i = 8'($urandom % 128);
      end
      snap_avail = gate && (wr_ptr - rd_ptr >= 53);
      snap_rd = rd_ptr;
      armed = 1;
    end
  endtask

  initial begin
    void'($urandom(32'h0BADCE11));
    // R1 reset state
    repeat (3) @(negedge clk_i);
    chk(cell_data_o == 0 && cell_soc_o == 0 && valid_cell_o == 0, "R1 outputs in reset",
        {cell_data_o, cell_soc_o, valid_cell_o}, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    rd_chk(CTRL, 8'h00, "R1 control reset");
    rd_chk(IDLE + 0, 8'h00, "R1 idle hdr1 default");
    rd_chk(IDLE + 1, 8'h00, "R1 idle hdr2 default");
    rd_chk(IDLE + 2, 8'h00, "R1 idle hdr3 default");
    rd_chk(IDLE + 3, 8'h01, "R1 idle hdr4 default");
    rd_chk(IDLE + 4, 8'h52, "R1 idle hdr5 default");
    rd_chk(IDLE + 5, 8'h6A, "R1 idle payload default");
    // program OAM buffer and idle pattern
    for (int i = 0; i < 53; i++) begin
      oam_m[i] = 8'($urandom);
      wr(8'(i), oam_m[i]);
    end
    for (int i = 0; i < 5; i++) begin
      hdr_m[i] = 8'($urandom);
      wr(IDLE + 8'(i), hdr_m[i]);
    end
    pay_m = 8'($urandom);
    wr(IDLE + 5, pay_m);
    rd_chk(8'd0, oam_m[0], "R9 oam buffer readback first");
    rd_chk(8'd52, oam_m[52], "R9 oam buffer readback last");
    rd_chk(IDLE + 4, hdr_m[4], "R9 idle hdr5 readback");
    rd_chk(IDLE + 5, pay_m, "R9 idle payload readback");
    wr(CTRL, 8'h7F);
    rd_chk(CTRL, 8'h00, "R9 control low bits ignored");
    // checked phases
    run(300, 0, 0);   // idle only
    run(150, 0, 2);   // OAM against idle
    run(5000, 2, 1);  // random mix
    run(600, 1, 2);   // OAM contending with user cells each boundary
    run(200, 1, 0);   // back-to-back user cells
    run(120, 0, 0);   // drain
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule